// File: doc/BRIEF.md
# Dithered Quadrature Phase-Accumulator Oscillator

This block is a numerically controlled oscillator that produces a pair of quadrature samples, a cosine and a sine, for a complex down-converting mixer placed after it. A 32-bit unsigned tuning word is added to a phase register on every sample clock where the enable is high. The output frequency is therefore `phase_inc * Fs / 2^32`, which gives a tuning step of Fs/2^32. The usable range runs up to Fs/2.

Only the top 12 bits of the phase select a waveform point, so each output step is 2π/4096 radians. The discarded fraction causes periodic truncation spurs. To spread that error into a noise floor, the block can add a pseudo-random offset before truncation. The offset comes from a seeded linear-feedback shift register, and a build-time switch turns it on or off. The waveform itself comes from a quarter-wave table that is computed at elaboration and unfolded by quadrant symmetry.

Top module: `nco_dither`

## Requirements
- R1: On each rising clock edge with `en` high, the phase register becomes its previous value plus `phase_inc`, modulo 2^32. It wraps silently.
- R2: The waveform address is bits [31:20] of (phase register + dither term) modulo 2^32. Both operands are the values held before the edge.
- R3: At each enabled edge, `cos_out` is updated to round(32767·cos(2π·a/4096)) and `sin_out` to round(32767·sin(2π·a/4096)). Here `a` is the address from the pre-edge state, and rounding is half away from zero. Both outputs are 16-bit two's complement, and neither ever takes the value -32768.
- R4: Whenever the address lies in the first quadrant (address bits [11:10] = 0), both outputs produced from it are non-negative.
- R5: With `en` low, the phase register, the random generator and both outputs hold their values, whatever `phase_inc` does.
- R6: A low `rst_n` acts at once, without waiting for a clock edge. While it is low, the phase register is 0, the random generator holds `SEED`, and both outputs are 0.
- R7: When `DITHER_EN` is 1, the dither term is the low 20 bits of the 32-bit random register. On each enabled edge that register advances by one step: shift right one place, then XOR with 0x80200003 if the bit shifted out was 1. The register never becomes zero.
- R8: When `DITHER_EN` is 0, the dither term is zero, so the address is simply the top 12 bits of the phase register.
- R9: With `phase_inc` = 0x80000000 and dither off, from phase 0, `cos_out` alternates between +32767 and -32767 and `sin_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; advances all state when high |
| phase_inc | input | 32 | Unsigned phase step per enabled sample |
| cos_out | output | 16 | Signed cosine sample |
| sin_out | output | 16 | Signed sine sample |

## Verification
The assertions assume that `SEED` is nonzero. With a zero seed the random register would stay at zero, and the liveness check on it would fail. They also assume that `en` and `phase_inc` are settled before each rising edge. The bench therefore changes every input only on falling edges and uses a nonzero seed.

Dithered and undithered copies run side by side against a behavioural model. The stimulus covers several fixed tuning words, including a zero step, the Nyquist step and a step that wraps on nearly every sample. It also applies random tuning words under a random enable, and a reset in the middle of the run.

// File: rtl/nco_dither.sv
`timescale 1ns/1ps
module nco_dither #(
  parameter int          PHASE_W   = 32,
  parameter int          ADDR_W    = 12,
  parameter int          OUT_W     = 16,
  parameter int          DITHER_W  = 20,
  parameter bit          DITHER_EN = 1'b1,
  parameter logic [31:0] SEED      = 32'h1D87_2B41
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [PHASE_W-1:0]       phase_inc,
  output logic signed [OUT_W-1:0]  cos_out,
  output logic signed [OUT_W-1:0]  sin_out
);
  localparam int          QW        = ADDR_W - 2;
  localparam int          QN        = 1 << QW;
  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

  function automatic logic signed [OUT_W-1:0] qsin(input int k);
    real v;
    v = real'((1 << (OUT_W-1)) - 1) *
        $sin(2.0 * 3.14159265358979 * real'(k) / real'(4 * QN));
    return OUT_W'($rtoi(v + 0.5));
  endfunction

  logic signed [OUT_W-1:0] qtab [0:QN];
  for (genvar k = 0; k <= QN; k++) begin : g_tab
    assign qtab[k] = qsin(k);
  end

  logic [PHASE_W-1:0] acc;
  logic [31:0]        lfsr;
  logic [PHASE_W-1:0] dith, phase_d;
  logic [ADDR_W-1:0]  addr;
  logic [QW:0]        idx_a, idx_b;
  logic signed [OUT_W-1:0] ta, tb, c_nx, s_nx;

  if (DITHER_EN) begin : g_dith
    assign dith = {{(PHASE_W-DITHER_W){1'b0}}, lfsr[DITHER_W-1:0]};
  end else begin : g_nodith
    assign dith = '0;
  end

  assign phase_d = acc + dith;
  assign addr    = phase_d[PHASE_W-1 -: ADDR_W];
  assign idx_a   = {1'b0, addr[QW-1:0]};
  assign idx_b   = (QW+1)'(QN) - idx_a;
  assign ta      = qtab[idx_a];
  assign tb      = qtab[idx_b];

  always_comb begin
    case (addr[ADDR_W-1 -: 2])
      2'd0:    begin s_nx = ta;  c_nx = tb;  end
      2'd1:    begin s_nx = tb;  c_nx = -ta; end
      2'd2:    begin s_nx = -ta; c_nx = -tb; end
      default: begin s_nx = -tb; c_nx = ta;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      lfsr    <= SEED;
      cos_out <= '0;
      sin_out <= '0;
    end else if (en) begin
      acc     <= acc + phase_inc;
      lfsr    <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? LFSR_MASK : 32'h0);
      cos_out <= c_nx;
      sin_out <= s_nx;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc) && $stable(cos_out) && $stable(sin_out));

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 32'h0);

  assert_no_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cos_out != {1'b1, {(OUT_W-1){1'b0}}} && sin_out != {1'b1, {(OUT_W-1){1'b0}}});

  assert_first_quad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && addr[ADDR_W-1 -: 2] == 2'd0 |=> cos_out >= 0 && sin_out >= 0);
endmodule

// File: tb/tb_nco_dither.sv
`timescale 1ns/1ps
module tb_nco_dither;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] phase_inc = '0;
  logic signed [15:0] cos_d, sin_d, cos_n, sin_n;
  int vectors = 0, errors = 0;
  string tag = "R6";

  always #10 clk = ~clk;

  nco_dither #(.DITHER_EN(1'b1), .SEED(32'h1D87_2B41)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc),
    .cos_out(cos_d), .sin_out(sin_d));
  nco_dither #(.DITHER_EN(1'b0), .SEED(32'h1D87_2B41)) dut_nd (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc),
    .cos_out(cos_n), .sin_out(sin_n));

  function automatic int wave(input int a, input bit is_cos);
    real v;
    real ang;
    ang = 2.0 * 3.14159265358979 * real'(a) / 4096.0;
    v = 32767.0 * (is_cos ? $cos(ang) : $sin(ang));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  longint m_acc, m_lfsr;
  int e_cd, e_sd, e_cn, e_sn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_lfsr = 64'h1D87_2B41;
      e_cd = 0; e_sd = 0; e_cn = 0; e_sn = 0;
    end else if (en) begin
      longint pd;
      int ad, an;
      pd = (m_acc + (m_lfsr % (64'd1 << 20))) % (64'd1 << 32);
      ad = int'(pd >> 20);
      an = int'(m_acc >> 20);
      e_cd = wave(ad, 1'b1); e_sd = wave(ad, 1'b0);
      e_cn = wave(an, 1'b1); e_sn = wave(an, 1'b0);
      m_acc = (m_acc + longint'(phase_inc)) % (64'd1 << 32);
      if (m_lfsr % 2 == 1) m_lfsr = (m_lfsr / 2) ^ 64'h8020_0003;
      else m_lfsr = m_lfsr / 2;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (int'(cos_d) != e_cd || int'(sin_d) != e_sd) begin
      errors++;
      $display("FAIL %s/R7 dithered: cos=%0d sin=%0d expected cos=%0d sin=%0d",
               tag, cos_d, sin_d, e_cd, e_sd);
    end
    if (int'(cos_n) != e_cn || int'(sin_n) != e_sn) begin
      errors++;
      $display("FAIL %s/R8 undithered: cos=%0d sin=%0d expected cos=%0d sin=%0d",
               tag, cos_n, sin_n, e_cn, e_sn);
    end
  end

  task automatic run(input int n, input logic [31:0] inc, input bit rnd_inc,
                     input int en_mode, input string t);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      phase_inc = rnd_inc ? $urandom : inc;
      en = (en_mode == 0) ? 1'b0 : (en_mode == 1) ? 1'b1 : 1'($urandom % 2);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tag = "R6";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    run(20, 32'h1234_5678, 1'b0, 0, "R5");
    run(20, 32'h0, 1'b0, 1, "R1");
    run(600, 32'h0100_0000, 1'b0, 1, "R3");
    @(negedge clk); #1 rst_n = 1'b0; en = 1'b0; tag = "R6";
    @(negedge clk); #1 rst_n = 1'b1;
    run(20, 32'h8000_0000, 1'b0, 1, "R9");
    run(200, 32'hFFFF_F000, 1'b0, 1, "R1");
    run(400, 32'h0040_0000, 1'b0, 1, "R4");
    run(1500, 32'h0, 1'b1, 2, "R7");
    run(200, 32'h0765_4321, 1'b0, 2, "R5");
    @(negedge clk); #3 rst_n = 1'b0; tag = "R6";
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    run(500, 32'h0001_2345, 1'b0, 1, "R2");
    run(300, 32'h0, 1'b1, 1, "R8");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule